// File: doc/BRIEF.md
# Programmable PWM Channel with Register Window

This block generates one pulse-width modulated waveform from a small register window. Software programs a period, a duty value and a control word, and can also load the running count directly, for example to put back a value saved before a power-down. The block counts clock ticks produced by an integer prescaler. It drives the output to an active or inactive level depending on where the count stands relative to the duty value.

The control word chooses the following:
- the level that counts as active;
- the level held while the channel is off;
- a left-aligned sawtooth count or a centre-aligned up/down count;
- free-running repetition or a single period that switches itself off.

Period and duty writes made while the channel runs are held back until the current period ends, so the waveform never carries a truncated or stretched pulse. The window occupies 16 bytes. A multi-channel wrapper places further channels at 16-byte steps and decodes the upper address bits outside this block.

Top module: `pwm_chan_top`

## Requirements
- R1: After synchronous reset, every register reads 0 and `pwm_out` is low.
- R2: Word offsets are 0x0 count, 0x4 period, 0x8 duty and 0xC control. Period and duty read back as written. In the control word:
  - bit 0 is enable;
  - bit 1 is continuous mode;
  - bit 3 is the active level;
  - bit 4 is the idle level;
  - bit 5 selects centre alignment;
  - bits 18:16 hold the prescale value.

  All other control bits read 0 whatever is written, so writing 0xFFFFFFFE reads back 0x0007003A.
- R3: While enable is 0, `pwm_out` equals the idle-level bit and the count does not change.
- R4: In left-aligned mode the count runs 0 to P-1 and wraps to 0 (P is the period). The output is at the active level (bit 3) while count < duty and at its inverse otherwise.
- R5: In centre-aligned mode the count runs 0 up to P-1 and then P-1 down to 0, giving 2P ticks per period. The output is active while count + duty >= P, which places the active phase in the middle.
- R6: The count advances once every (prescale+1) clocks. The first advance comes prescale+1 clocks after enabling.
- R7: With bit 1 = 0, the channel runs exactly one period. At the end of that period it clears the enable bit, and the output returns to the idle level. In left-aligned mode the count returns to 0 at that point.
- R8: A duty of 0 gives the inactive level for the whole period. A duty >= period gives the active level for the whole period.
- R9: A write to the count register loads the count directly. The loaded value is the starting point when the channel is next enabled, and the count direction restarts upward.
- R10: Period and duty writes made while enabled take effect only at the next period boundary. While disabled they take effect at once.
- R11: A programmed period of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset in the register window (bits 3:2 pick the word) |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench rewrites duty and period in the middle of a running period. A design without the boundary hold would show a pulse of the wrong length in that same period, and the bench catches it. It runs centre-aligned periods of 2P ticks with the repeated turning counts at the top and bottom. An up/down counter that skips either turning count would produce a waveform out of phase with the bench's expected values.

Further runs cover the remaining corners:
- one-shot runs in both alignments, where a design that fails to clear enable keeps toggling past the end of the period;
- a zero period, where a design that does not clamp it counts through the whole range instead of holding the output steady;
- a restored count that is not zero, which shows whether the load takes effect and whether the wrap happens at P-1;
- a duty of 0 and a duty larger than the period, where the output must stay flat for the whole period.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int DATA_W     = 32;
    localparam int CNT_W_DEF  = 16;
    localparam int ADDR_W     = 4;
    localparam int PS_W       = 3;
    localparam int PS_LSB     = 16;
    localparam int USED_TOP   = PS_LSB + PS_W;

    // word index within the window (bus_addr[3:2])
    localparam logic [1:0] WIDX_COUNT  = 2'd0;
    localparam logic [1:0] WIDX_PERIOD = 2'd1;
    localparam logic [1:0] WIDX_DUTY   = 2'd2;
    localparam logic [1:0] WIDX_CTRL   = 2'd3;

    // control word bit positions
    localparam int B_EN   = 0;
    localparam int B_CONT = 1;
    localparam int B_POL  = 3;
    localparam int B_IDLE = 4;
    localparam int B_CEN  = 5;

    typedef struct packed {
        logic [PS_W-1:0] presc;
        logic            center;
        logic            idle_lvl;
        logic            act_pol;
        logic            cont;
        logic            en;
    } ctrl_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_EN]              = c.en;
        w[B_CONT]            = c.cont;
        w[B_POL]             = c.act_pol;
        w[B_IDLE]            = c.idle_lvl;
        w[B_CEN]             = c.center;
        w[PS_LSB +: PS_W]    = c.presc;
        return w;
    endfunction

    function automatic logic drive_level(input logic active, input ctrl_t c);
        if (!c.en)
            return c.idle_lvl;
        return active ? c.act_pol : ~c.act_pol;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        word_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stop_req,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  period_w,
    output logic [CNT_W-1:0]  duty_w,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_ctrl;
    logic unused_hi;

    assign wr_ctrl    = wr_en && (word_idx == WIDX_CTRL);
    assign cnt_ld     = wr_en && (word_idx == WIDX_COUNT);
    assign cnt_ld_val = wr_data[CNT_W-1:0];
    assign unused_hi  = ^wr_data[DATA_W-1:USED_TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            period_w <= '0;
            duty_w   <= '0;
        end else if (wr_en) begin
            if (word_idx == WIDX_PERIOD) period_w <= wr_data[CNT_W-1:0];
            if (word_idx == WIDX_DUTY)   duty_w   <= wr_data[CNT_W-1:0];
        end
    end

    // a software write to control wins over the one-shot self-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en       <= wr_data[B_EN];
            ctrl.cont     <= wr_data[B_CONT];
            ctrl.act_pol  <= wr_data[B_POL];
            ctrl.idle_lvl <= wr_data[B_IDLE];
            ctrl.center   <= wr_data[B_CEN];
            ctrl.presc    <= wr_data[PS_LSB +: PS_W];
        end else if (stop_req) begin
            ctrl.en <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (word_idx)
            WIDX_COUNT:  rd_data[CNT_W-1:0] = cnt;
            WIDX_PERIOD: rd_data[CNT_W-1:0] = period_w;
            WIDX_DUTY:   rd_data[CNT_W-1:0] = duty_w;
            default:     rd_data = ctrl_to_word(ctrl);
        endcase
    end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             boundary,
    input  logic [CNT_W-1:0] period_w,
    input  logic [CNT_W-1:0] duty_w,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] duty_act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_clamped;

    assign per_clamped = (period_w == '0) ? ONE : period_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_act  <= ONE;
            duty_act <= '0;
        end else if (!en || boundary) begin
            per_act  <= per_clamped;
            duty_act <= duty_w;
        end
    end

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_chan_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] presc,
    output logic         tick
);

    logic [W-1:0] div_q;

    assign tick = en && (div_q >= presc);

    always_ff @(posedge clk) begin
        if (rst || !en || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] duty_act,
    input  logic             cnt_ld,
    input  logic [CNT_W-1:0] cnt_ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             boundary,
    output logic             pwm_out
);

    dir_t             dir;
    logic [CNT_W-1:0] top_val;
    logic             at_top;
    logic             step;
    logic             active;
    logic [CNT_W:0]   ctr_sum;

    assign top_val = per_act - 1'b1;
    assign at_top  = (cnt >= top_val);
    assign step    = ctrl.en && tick;

    generate
        if (CNT_W > 0) begin : g_bound
            always_comb begin
                if (ctrl.center)
                    boundary = step && (dir == DIR_DOWN) && (cnt == '0);
                else
                    boundary = step && at_top;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (cnt_ld) begin
            cnt <= cnt_ld_val;
            dir <= DIR_UP;
        end else if (step) begin
            if (!ctrl.center) begin
                cnt <= at_top ? '0 : cnt + 1'b1;
                dir <= DIR_UP;
            end else if (dir == DIR_UP) begin
                if (at_top) dir <= DIR_DOWN;
                else        cnt <= cnt + 1'b1;
            end else begin
                if (cnt == '0) dir <= DIR_UP;
                else           cnt <= cnt - 1'b1;
            end
        end
    end

    assign ctr_sum = {1'b0, cnt} + {1'b0, duty_act};

    always_comb begin
        if (ctrl.center)
            active = (ctr_sum >= {1'b0, per_act});
        else
            active = (cnt < duty_act);
        pwm_out = drive_level(active, ctrl);
    end

endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_w, duty_w, per_act, duty_act;
    logic [CNT_W-1:0] cnt, cnt_ld_val;
    logic             cnt_ld, tick, boundary, stop_req, ctrl_wr;
    logic [1:0]       word_idx;
    logic             unused_addr;

    assign word_idx    = bus_addr[3:2];
    assign unused_addr = ^bus_addr[1:0];
    assign stop_req    = boundary && !ctrl_q.cont;
    assign ctrl_wr     = bus_we && (word_idx == WIDX_CTRL);

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_we),
        .word_idx   (word_idx),
        .wr_data    (bus_wdata),
        .stop_req   (stop_req),
        .cnt        (cnt),
        .ctrl       (ctrl_q),
        .period_w   (period_w),
        .duty_w     (duty_w),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .rd_data    (bus_rdata)
    );

    pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .boundary (boundary),
        .period_w (period_w),
        .duty_w   (duty_w),
        .per_act  (per_act),
        .duty_act (duty_act)
    );

    pwm_prescale #(.W(PS_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl_q.en),
        .presc (ctrl_q.presc),
        .tick  (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl_q),
        .tick       (tick),
        .per_act    (per_act),
        .duty_act   (duty_act),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .cnt        (cnt),
        .boundary   (boundary),
        .pwm_out    (pwm_out)
    );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input ctrl_t            ctrl,
    input logic             tick,
    input logic             boundary,
    input logic             cnt_ld,
    input logic             ctrl_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] duty_act
);

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (pwm_out == ctrl.idle_lvl));

    assert_hold_count_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !cnt_ld) |=> $stable(cnt));

    assert_prescale_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.presc != '0 && !ctrl_wr) |=> !tick);

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !ctrl.cont && boundary && !ctrl_wr) |=> !ctrl.en);

    assert_duty_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && duty_act == '0) |-> (pwm_out == ~ctrl.act_pol));

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !boundary) |=> ($stable(per_act) && $stable(duty_act)));

    assert_period_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        per_act != '0);

endmodule

bind pwm_chan_top pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwm_out  (pwm_out),
    .ctrl     (ctrl_q),
    .tick     (tick),
    .boundary (boundary),
    .cnt_ld   (cnt_ld),
    .ctrl_wr  (ctrl_wr),
    .cnt      (cnt),
    .per_act  (per_act),
    .duty_act (duty_act)
);

// File: tb/tb_pwm_chan_top.sv
module tb_pwm_chan_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    always #5 clk = ~clk;

    pwm_chan_top dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;

    // expectation model parameters
    int    e_per = 1, e_duty = 0, e_per2 = 1, e_duty2 = 0;
    int    e_sw = 1000000, e_ps = 0, e_c0 = 0;
    bit    e_pol, e_idle, e_cen, e_cont;

    function automatic logic [31:0] mk_ctrl(bit en, bit cont, bit pol,
                                            bit idle, bit cen, int ps);
        return {13'b0, ps[2:0], 10'b0, cen, idle, pol, 1'b0, cont, en};
    endfunction

    function automatic logic exp_level(int t);
        int  k, kk, m, c;
        bit  act;
        if (t >= e_sw) begin
            k   = (t - e_sw) / (e_ps + 1);
            c   = k % e_per2;
            act = (c < e_duty2);
            return act ? e_pol : ~e_pol;
        end
        k = t / (e_ps + 1);
        if (e_cen) begin
            if (!e_cont && k >= 2 * e_per) return e_idle;
            m   = k % (2 * e_per);
            c   = (m < e_per) ? m : (2 * e_per - 1 - m);
            act = (c + e_duty >= e_per);
        end else begin
            kk = e_c0 + k;
            if (!e_cont && kk >= e_per) return e_idle;
            c   = kk % e_per;
            act = (c < e_duty);
        end
        return act ? e_pol : ~e_pol;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: pops one expected level per cycle while the queue is filled
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.tag, {31'b0, pwm_out}, {31'b0, e.lvl});
        end
    end

    task automatic reg_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cfg(int per, int duty, int c0);
        reg_wr(4'h4, per);
        reg_wr(4'h8, duty);
        reg_wr(4'h0, c0);
        e_per  = (per == 0) ? 1 : per;
        e_duty = duty;
        e_c0   = c0;
        e_sw   = 1000000;
    endtask

    // driver: enabling write, then expected levels pushed to the scoreboard
    task automatic start_run(logic [31:0] cw, int n, string tag);
        e_cont = cw[1];
        e_pol  = cw[3];
        e_idle = cw[4];
        e_cen  = cw[5];
        e_ps   = int'(cw[18:16]);
        @(negedge clk);
        bus_addr  = 4'hC;
        bus_wdata = cw;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        for (int t = 0; t < n; t++) begin
            exp_t e;
            e.lvl = exp_level(t);
            e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pwm_out", {31'b0, pwm_out}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4), d);
            chk("R1 reg", d, 32'h0);
        end

        // R2: readback and unimplemented control bits; R3 idle level
        reg_wr(4'h4, 32'h0000_1234);
        rd(4'h4, d);  chk("R2 period", d, 32'h1234);
        reg_wr(4'h8, 32'h0000_ABCD);
        rd(4'h8, d);  chk("R2 duty", d, 32'hABCD);
        reg_wr(4'hC, 32'hFFFF_FFFE);
        rd(4'hC, d);  chk("R2 ctrl mask", d, 32'h0007_003A);
        chk("R3 idle high", {31'b0, pwm_out}, 32'h1);
        reg_wr(4'hC, 32'h0);
        chk("R3 idle low", {31'b0, pwm_out}, 32'h0);

        // R4: left aligned, active high
        cfg(5, 2, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 20, "R4 left");
        drain(); reg_wr(4'hC, 0);

        // R6 with R4 polarity: prescale 2, active low, idle high
        cfg(4, 3, 0);
        start_run(mk_ctrl(1, 1, 0, 1, 0, 2), 30, "R6 prescale");
        drain(); reg_wr(4'hC, 0);

        // R5: centre aligned
        cfg(4, 2, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 1, 1), 40, "R5 centre ps1");
        drain(); reg_wr(4'hC, 0);
        cfg(5, 1, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 1, 0), 30, "R5 centre narrow");
        drain(); reg_wr(4'hC, 0);

        // R8: duty extremes
        cfg(5, 0, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 12, "R8 duty zero");
        drain(); reg_wr(4'hC, 0);
        cfg(5, 9, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 1, 0), 20, "R8 duty over period");
        drain(); reg_wr(4'hC, 0);

        // R11: period 0 acts as 1
        cfg(0, 1, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 10, "R11 zero period");
        drain(); reg_wr(4'hC, 0);

        // R9: restored count
        cfg(5, 2, 3);
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 15, "R9 count load");
        drain(); reg_wr(4'hC, 0);

        // R7: one-shot, left and centre
        cfg(3, 1, 0);
        start_run(mk_ctrl(1, 0, 1, 0, 0, 0), 12, "R7 oneshot left");
        drain();
        rd(4'hC, d);  chk("R7 enable cleared", d, 32'h0000_0008);
        rd(4'h0, d);  chk("R7 count at 0", d, 32'h0);
        cfg(2, 1, 0);
        start_run(mk_ctrl(1, 0, 1, 0, 1, 0), 10, "R7 oneshot centre");
        drain();
        rd(4'hC, d);  chk("R7 centre enable cleared", d, 32'h0000_0028);

        // R10: mid-period duty/period writes wait for the boundary
        cfg(5, 1, 0);
        e_per2  = 8;
        e_duty2 = 4;
        e_sw    = 5;
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 30, "R10 shadow");
        reg_wr(4'h8, 32'd4);
        reg_wr(4'h4, 32'd8);
        drain(); reg_wr(4'hC, 0);

        // R3: disabling mid-run gives idle level and a frozen count
        cfg(5, 2, 0);
        start_run(mk_ctrl(1, 1, 1, 0, 0, 0), 7, "R3 pre-disable");
        drain();
        reg_wr(4'hC, mk_ctrl(0, 1, 1, 1, 0, 0));
        chk("R3 idle after disable", {31'b0, pwm_out}, 32'h1);
        rd(4'h0, d);
        repeat (5) @(negedge clk);
        rd(4'h0, d2);
        chk("R3 count frozen", d2, d);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule